// File: doc/BRIEF.md
# Receiver Loss-of-Lock Controller

This block decides whether a clock-and-data-recovery receiver has lost lock and steers the reaction to that decision. Three candidate lock-loss indications arrive at its inputs: a jitter estimate compared against a programmable limit, a frequency-deviation flag produced elsewhere, and a loss-of-signal flag. Two mode bits and the reference-enable input choose which of these drives the loss-of-lock state. An optional enable lets an active loss-of-signal force loss-of-lock on.

Each time the loss-of-lock state changes, the block issues a one-cycle write toward the receiver's loop-acquisition control register. The data is a fast-acquisition code while lock is lost and a tracking code once lock returns. It also keeps a sticky interrupt bit with a separate enable, exposes the live loss-of-lock state, and can zero the receive data path while lock is lost.

Top module: `lock_loss_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the loss-of-lock state, the jitter decision, the sticky interrupt bit and the acquisition strobe, and sets the acquisition data to 00h.
- R2: The jitter decision becomes 1 when the measure is greater than the threshold and 0 when it is smaller. A measure equal to the threshold keeps the previous decision.
- R3: `src_mode` picks the source. 2'b00 uses the jitter decision when `ref_en` is 0 and the frequency flag when `ref_en` is 1. 2'b01 always uses the jitter decision. 2'b10 always uses the frequency flag. 2'b11 uses the OR of both.
- R4: The jitter decision is updated every cycle even while another source is selected, so switching to it shows its current value.
- R5: When `los_lol_en` is 1, an active `los` forces loss-of-lock on. When `los_lol_en` is 0, `los` has no effect.
- R6: `lol` is registered: it shows, one clock edge later, the result of the inputs sampled at that edge.
- R7: On the edge where `lol` changes, `acq_wr` is high for exactly one cycle and `acq_data` shows 98h if `lol` became 1 or 00h if it became 0. No strobe occurs without a change.
- R8: `acq_data` only ever holds 98h or 00h, and it keeps its value between strobes.
- R9: `irq_sticky` sets on the edge where `lol` rises and clears on an edge with `irq_clr` high. If both happen on the same edge, setting wins.
- R10: `irq` equals `irq_sticky` when `irq_en` is 1 and is 0 otherwise.
- R11: `rx_data_out` is all zeros while both `squelch_en` and `lol` are 1. Otherwise it equals `rx_data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jit_meas | input | MEAS_W | Jitter measure from the estimator |
| jit_thresh | input | MEAS_W | Programmable jitter limit |
| freq_lol | input | 1 | Frequency-deviation lock-loss flag |
| los | input | 1 | Loss-of-signal flag |
| ref_en | input | 1 | Reference clock enabled (affects automatic source mode) |
| src_mode | input | 2 | Lock-loss source selection |
| los_lol_en | input | 1 | Allow loss-of-signal to force lock loss |
| squelch_en | input | 1 | Zero receive data during lock loss |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the sticky bit |
| rx_data_in | input | DATA_W | Receive data in |
| rx_data_out | output | DATA_W | Receive data out, possibly squelched |
| lol | output | 1 | Live loss-of-lock alarm status |
| irq_sticky | output | 1 | Sticky interrupt status bit |
| irq | output | 1 | Gated interrupt output |
| acq_wr | output | 1 | One-cycle write strobe for the loop-acquisition register |
| acq_data | output | 8 | Loop-acquisition register value |

## Verification
A sequence of jitter measures above, below and exactly at the threshold shows the difference between assert, release and hold. The same measures under each source mode, with the frequency flag set against them, show whether the selected source or a masked one drives the state. One step switches to jitter mode at an equal measure, which reveals whether the hidden jitter decision was tracked in the background. Loss-of-signal is applied both with and without its enable to tell forcing apart from being ignored. Strobe and data are checked on every step, so a missing, extra or stuck acquisition write shows up.

// File: rtl/lock_loss_pkg.sv
package lock_loss_pkg;

    typedef enum logic [1:0] {
        SRC_AUTO   = 2'b00,
        SRC_JITTER = 2'b01,
        SRC_FREQ   = 2'b10,
        SRC_ANY    = 2'b11
    } lol_src_e;

    localparam logic [7:0] ACQ_HUNT  = 8'h98;
    localparam logic [7:0] ACQ_TRACK = 8'h00;

    typedef struct packed {
        logic jitter;
        logic freq;
        logic los;
    } lol_cand_t;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } acq_cmd_t;

    function automatic logic pick_source(input lol_src_e mode, input logic ref_on,
                                         input lol_cand_t c, input logic los_force_en);
        logic base;
        case (mode)
            SRC_AUTO:   base = ref_on ? c.freq : c.jitter;
            SRC_JITTER: base = c.jitter;
            SRC_FREQ:   base = c.freq;
            default:    base = c.jitter | c.freq;
        endcase
        return base | (los_force_en & c.los);
    endfunction

    function automatic logic [7:0] acq_code(input logic lost);
        return lost ? ACQ_HUNT : ACQ_TRACK;
    endfunction

endpackage

// File: rtl/lol_jitter_cmp.sv
module lol_jitter_cmp #(
    parameter int MEAS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEAS_W-1:0] meas,
    input  logic [MEAS_W-1:0] thresh,
    output logic              jit_next
);
    logic jit_state;
    logic above;
    logic below;

    assign above = meas > thresh;
    assign below = meas < thresh;

    always_comb begin
        if (above)      jit_next = 1'b1;
        else if (below) jit_next = 1'b0;
        else            jit_next = jit_state;
    end

    always_ff @(posedge clk) begin
        if (rst) jit_state <= 1'b0;
        else     jit_state <= jit_next;
    end
endmodule

// File: rtl/lol_acq_seq.sv
module lol_acq_seq
    import lock_loss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lol_next,
    output logic       lol_q,
    output logic       lol_rise,
    output acq_cmd_t   acq
);
    logic change;

    assign change   = lol_next ^ lol_q;
    assign lol_rise = lol_next & ~lol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lol_q    <= 1'b0;
            acq.wr   <= 1'b0;
            acq.data <= ACQ_TRACK;
        end else begin
            lol_q  <= lol_next;
            acq.wr <= change;
            if (change) acq.data <= acq_code(lol_next);
        end
    end
endmodule

// File: rtl/lol_status_regs.sv
module lol_status_regs (
    input  logic clk,
    input  logic rst,
    input  logic lol_rise,
    input  logic irq_clr,
    input  logic irq_en,
    output logic irq_sticky,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)           irq_sticky <= 1'b0;
        else if (lol_rise) irq_sticky <= 1'b1;
        else if (irq_clr)  irq_sticky <= 1'b0;
    end

    assign irq = irq_sticky & irq_en;
endmodule

// File: rtl/lol_squelch_gate.sv
module lol_squelch_gate #(
    parameter int DATA_W = 32
) (
    input  logic              kill,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = din[b] & ~kill;
    end
endmodule

// File: rtl/lock_loss_ctrl.sv
module lock_loss_ctrl
    import lock_loss_pkg::*;
#(
    parameter int MEAS_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEAS_W-1:0] jit_meas,
    input  logic [MEAS_W-1:0] jit_thresh,
    input  logic              freq_lol,
    input  logic              los,
    input  logic              ref_en,
    input  logic [1:0]        src_mode,
    input  logic              los_lol_en,
    input  logic              squelch_en,
    input  logic              irq_en,
    input  logic              irq_clr,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [DATA_W-1:0] rx_data_out,
    output logic              lol,
    output logic              irq_sticky,
    output logic              irq,
    output logic              acq_wr,
    output logic [7:0]        acq_data
);
    logic      jit_next;
    logic      lol_next;
    logic      lol_rise;
    lol_cand_t cand;
    acq_cmd_t  acq;

    lol_jitter_cmp #(.MEAS_W(MEAS_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .meas     (jit_meas),
        .thresh   (jit_thresh),
        .jit_next (jit_next)
    );

    assign cand.jitter = jit_next;
    assign cand.freq   = freq_lol;
    assign cand.los    = los;
    assign lol_next    = pick_source(lol_src_e'(src_mode), ref_en, cand, los_lol_en);

    lol_acq_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .lol_next (lol_next),
        .lol_q    (lol),
        .lol_rise (lol_rise),
        .acq      (acq)
    );

    assign acq_wr   = acq.wr;
    assign acq_data = acq.data;

    lol_status_regs u_stat (
        .clk        (clk),
        .rst        (rst),
        .lol_rise   (lol_rise),
        .irq_clr    (irq_clr),
        .irq_en     (irq_en),
        .irq_sticky (irq_sticky),
        .irq        (irq)
    );

    lol_squelch_gate #(.DATA_W(DATA_W)) u_sq (
        .kill (squelch_en & lol),
        .din  (rx_data_in),
        .dout (rx_data_out)
    );
endmodule

// File: rtl/lock_loss_ctrl_chk.sv
module lock_loss_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lol,
    input logic              acq_wr,
    input logic [7:0]        acq_data,
    input logic              irq_sticky,
    input logic              los,
    input logic              los_lol_en,
    input logic              squelch_en,
    input logic [DATA_W-1:0] rx_data_out
);
    AST_ACQ_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) (acq_data == 8'h98) || (acq_data == 8'h00)); // R8
    AST_ACQ_HELD: assert property (@(posedge clk) disable iff (rst) !acq_wr |-> $stable(acq_data)); // R8
    AST_ACQ_ON_CHANGE: assert property (@(posedge clk) disable iff (rst) (lol != $past(lol)) |-> acq_wr); // R7
    AST_ACQ_MATCHES_LOL: assert property (@(posedge clk) disable iff (rst) acq_wr |-> (acq_data == (lol ? 8'h98 : 8'h00))); // R7
    AST_STICKY_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(irq_sticky) |-> (lol && !$past(lol))); // R9
    AST_LOS_FORCES: assert property (@(posedge clk) disable iff (rst) (los && los_lol_en) |=> lol); // R5
    AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (rst) (squelch_en && lol) |-> (rx_data_out == '0)); // R11
endmodule

bind lock_loss_ctrl lock_loss_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lol         (lol),
    .acq_wr      (acq_wr),
    .acq_data    (acq_data),
    .irq_sticky  (irq_sticky),
    .los         (los),
    .los_lol_en  (los_lol_en),
    .squelch_en  (squelch_en),
    .rx_data_out (rx_data_out)
);

// File: tb/lock_loss_ctrl_test.sv
module lock_loss_ctrl_test;
    localparam int MEAS_W = 12;
    localparam int DATA_W = 32;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [MEAS_W-1:0] jit_meas = '0;
    logic [MEAS_W-1:0] jit_thresh = 12'h100;
    logic              freq_lol = 1'b0;
    logic              los = 1'b0;
    logic              ref_en = 1'b0;
    logic [1:0]        src_mode = 2'b00;
    logic              los_lol_en = 1'b0;
    logic              squelch_en = 1'b0;
    logic              irq_en = 1'b1;
    logic              irq_clr = 1'b0;
    logic [DATA_W-1:0] rx_data_in = '0;
    logic [DATA_W-1:0] rx_data_out;
    logic              lol, irq_sticky, irq, acq_wr;
    logic [7:0]        acq_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lock_loss_ctrl #(.MEAS_W(MEAS_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .jit_meas(jit_meas), .jit_thresh(jit_thresh),
        .freq_lol(freq_lol), .los(los), .ref_en(ref_en), .src_mode(src_mode),
        .los_lol_en(los_lol_en), .squelch_en(squelch_en), .irq_en(irq_en),
        .irq_clr(irq_clr), .rx_data_in(rx_data_in), .rx_data_out(rx_data_out),
        .lol(lol), .irq_sticky(irq_sticky), .irq(irq), .acq_wr(acq_wr),
        .acq_data(acq_data)
    );

    // row: mode[31:30] ref_en[29] los_lol_en[28] los[27] freq[26] meas[25:14] thresh[13:2] exp_lol[1] exp_wr[0]
    localparam logic [31:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h050, 12'h100, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h150, 12'h100, 1'b1, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h100, 12'h100, 1'b1, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0FF, 12'h100, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h100, 12'h100, 1'b0, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 12'h050, 12'h100, 1'b1, 1'b1},
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 12'h200, 12'h100, 1'b0, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 12'h100, 12'h100, 1'b1, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 12'h100, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h100, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 12'h300, 12'h100, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 12'h100, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h100, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 12'h100, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h100, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 12'h100, 1'b0, 1'b0}
    };

    function automatic string row_tag(input int i);
        if (i < 5)       return "R2";  // above, below and equal-to-threshold
        else if (i == 7) return "R4";  // hidden jitter decision tracked
        else if (i < 13) return "R3";  // source modes
        else             return "R5";  // loss-of-signal forcing
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic exp_sticky;
        logic prev_lol;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(lol == 1'b0, "R1", "lol", lol, 0);
        check(acq_data == 8'h00 && acq_wr == 1'b0, "R1", "acq", {acq_wr, acq_data}, 0);
        check(irq_sticky == 1'b0, "R1", "sticky", irq_sticky, 0);
        rst = 1'b0;
        exp_sticky = 1'b0;
        prev_lol = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            src_mode   = v[31:30];
            ref_en     = v[29];
            los_lol_en = v[28];
            los        = v[27];
            freq_lol   = v[26];
            jit_meas   = v[25:14];
            jit_thresh = v[13:2];
            step();
            // R6: lol reflects inputs sampled at the single edge just passed
            check(lol == v[1], row_tag(i), "lol", lol, v[1]);
            check(acq_wr == v[0], "R7", "acq_wr", acq_wr, v[0]);
            check(acq_data == (v[1] ? 8'h98 : 8'h00), "R8", "acq_data", acq_data, v[1] ? 8'h98 : 8'h00);
            if (v[1] && !prev_lol) exp_sticky = 1'b1;
            prev_lol = v[1];
            check(irq_sticky == exp_sticky, "R9", "sticky", irq_sticky, exp_sticky);
            check(irq == exp_sticky, "R10", "irq", irq, exp_sticky);
        end

        // R7: no strobe while state holds
        step();
        check(acq_wr == 1'b0, "R7", "acq_wr idle", acq_wr, 0);

        // R9 clear by write-one
        irq_clr = 1'b1;
        step();
        check(irq_sticky == 1'b0, "R9", "clear", irq_sticky, 0);

        // R9 set wins over simultaneous clear
        src_mode = 2'b01;
        los_lol_en = 1'b0;
        jit_meas = 12'h300;
        step();
        check(lol == 1'b1, "R2", "lol rise", lol, 1);
        check(irq_sticky == 1'b1, "R9", "set wins", irq_sticky, 1);
        irq_clr = 1'b0;

        // R10 gating
        irq_en = 1'b0;
        #1;
        check(irq == 1'b0, "R10", "gated", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq == 1'b1, "R10", "enabled", irq, 1);

        // R11 squelch
        rx_data_in = 32'hA5A5_5A5A;
        squelch_en = 1'b1;
        #1;
        check(rx_data_out == '0, "R11", "squelched", rx_data_out, 0);
        squelch_en = 1'b0;
        #1;
        check(rx_data_out == rx_data_in, "R11", "pass lol", rx_data_out, rx_data_in);
        @(negedge clk);
        jit_meas = 12'h000;
        squelch_en = 1'b1;
        step();
        check(lol == 1'b0, "R2", "lol fall", lol, 0);
        check(rx_data_out == rx_data_in, "R11", "pass locked", rx_data_out, rx_data_in);

        // R1 mid-run reset with lock lost
        jit_meas = 12'h300;
        step();
        check(lol == 1'b1, "R2", "lol before reset", lol, 1);
        rst = 1'b1;
        step();
        check(lol == 1'b0, "R1", "lol after reset", lol, 0);
        check(acq_data == 8'h00 && acq_wr == 1'b0, "R1", "acq after reset", {acq_wr, acq_data}, 0);
        check(irq_sticky == 1'b0, "R1", "sticky after reset", irq_sticky, 0);
        repeat (2) step();
        rst = 1'b0;
        step();
        check(lol == 1'b1 && acq_wr == 1'b1, "R7", "relock after reset", {lol, acq_wr}, 2'b11);

        finish_run();
    end
endmodule